// File: doc/BRIEF.md
# Single-Word Command Memory Target

This block is the target side of a simple point-to-point request/response link. A master presents a three-bit command code, an address and write data; the block answers from a small register array held inside it. A write stores the data word and is acknowledged with a one-cycle command accept only. A read is acknowledged with a one-cycle command accept that comes together with a data-valid response code and the stored word.

Each command is handled on its own: the control machine leaves idle on a write or read code, performs the access, raises its acknowledgement for one cycle and goes back to idle. A master is expected to hold its request until it sees the accept and then remove it; a command still present during the acknowledgement cycle is not started again. Only the low address bits select a word, so addresses that differ only in their upper bits name the same location. Memory contents are not cleared by reset.

Top module: `cmd_mem_target`

## Requirements
- R1: The command code 3'b001 is a write, 3'b010 is a read and 3'b000 is idle; every other code is ignored like idle, so it produces no accept and changes no stored word.
- R2: A write presented before clock edge N stores the write data at the addressed word and raises `cmd_accept` in the cycle after edge N+1, with `resp_code` at 2'b00 in that cycle.
- R3: A read presented before clock edge N raises `cmd_accept` in the cycle after edge N+1 together with `resp_code` 2'b01 and the word last written to that address on `resp_data`.
- R4: Whenever `cmd_accept` is low, `resp_code` is 2'b00 (no response) and `resp_data` is zero.
- R5: Every accept lasts exactly one cycle; a command still presented during that acknowledgement cycle is not started, so a master that holds its request until it sees the accept and then drops it gets a single accept.
- R6: The word is selected by the low clog2(DEPTH) address bits only; with DEPTH 16, addresses 8'h03, 8'h13 and 8'hF3 name the same word.
- R7: A synchronous reset returns the control machine to idle and drives `cmd_accept` low, `resp_code` to 2'b00 and `resp_data` to zero from the next edge, abandoning any command in progress.
- R8: `cmd_accept` is raised only when a write or read code was presented two edges before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_cmd | input | 3 | Command code from the master |
| req_addr | input | ADDR_W | Word address of the command |
| req_wdata | input | DATA_W | Data word to store on a write |
| cmd_accept | output | 1 | One-cycle acknowledgement of a command |
| resp_code | output | 2 | Response code: 2'b00 none, 2'b01 data valid |
| resp_data | output | DATA_W | Read word, valid with the data-valid code |

## Verification
Both the write accept and the read accept with its data come two clock edges after the command is first presented: one edge to move from idle into the access state and one to register the acknowledgement. The bench drives each command at a falling edge, checks that nothing is acknowledged one cycle later, checks the accept, code and data at the second falling edge, then withdraws the command and checks that the following cycle carries no accept. Expected read words come from a bench-side copy of the array indexed by the low address bits, and reads of words never written are checked for handshake only.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_WR   = 2'd1,
        K_RD   = 2'd2
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } state_e;

    localparam logic [2:0] CODE_IDLE  = 3'b000;
    localparam logic [2:0] CODE_WRITE = 3'b001;
    localparam logic [2:0] CODE_READ  = 3'b010;

    localparam logic [1:0] RESP_NUL = 2'b00;
    localparam logic [1:0] RESP_DVA = 2'b01;

endpackage

// File: rtl/cmt_decode.sv
module cmt_decode
    import cmt_pkg::*;
(
    input  logic [2:0] code,
    output kind_e      kind
);

    always_comb begin
        case (code)
            CODE_WRITE: kind = K_WR;
            CODE_READ:  kind = K_RD;
            default:    kind = K_NONE;
        endcase
    end

endmodule

// File: rtl/cmt_store.sv
module cmt_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (we && (idx == IDX_W'(g))) begin
                words[g] <= wdata;
            end
        end
    end

    assign rdata = words[idx];

endmodule

// File: rtl/cmt_fsm.sv
module cmt_fsm
    import cmt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  kind_e             kind,
    input  logic [IDX_W-1:0]  in_idx,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [IDX_W-1:0]  mem_idx,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              ack,
    output logic [1:0]        code,
    output logic [DATA_W-1:0] rword
);

    typedef struct packed {
        state_e            state;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] wdata;
        logic              ack;
        logic [1:0]        code;
        logic [DATA_W-1:0] rword;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.ack   = 1'b0;
        r_d.code  = RESP_NUL;
        r_d.rword = '0;
        case (r_q.state)
            ST_IDLE: begin
                // a request still held during the acknowledge cycle is not restarted
                if (!r_q.ack) begin
                    if (kind == K_WR) begin
                        r_d.state = ST_WRITE;
                        r_d.idx   = in_idx;
                        r_d.wdata = in_wdata;
                    end else if (kind == K_RD) begin
                        r_d.state = ST_READ;
                        r_d.idx   = in_idx;
                    end
                end
            end
            ST_WRITE: begin
                r_d.ack   = 1'b1;
                r_d.state = ST_IDLE;
            end
            ST_READ: begin
                r_d.ack   = 1'b1;
                r_d.code  = RESP_DVA;
                r_d.rword = mem_rdata;
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state <= ST_IDLE;
            r_q.idx   <= '0;
            r_q.wdata <= '0;
            r_q.ack   <= 1'b0;
            r_q.code  <= RESP_NUL;
            r_q.rword <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_we    = (r_q.state == ST_WRITE) && !rst;
    assign mem_idx   = r_q.idx;
    assign mem_wdata = r_q.wdata;
    assign ack       = r_q.ack;
    assign code      = r_q.code;
    assign rword     = r_q.rword;

endmodule

// File: rtl/cmd_mem_target.sv
module cmd_mem_target
    import cmt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              cmd_accept,
    output logic [1:0]        resp_code,
    output logic [DATA_W-1:0] resp_data
);

    localparam int IDX_W = $clog2(DEPTH);

    kind_e             kind;
    logic              mem_we;
    logic [IDX_W-1:0]  mem_idx;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;

    cmt_decode u_decode (
        .code (req_cmd),
        .kind (kind)
    );

    cmt_fsm #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .kind      (kind),
        .in_idx    (req_addr[IDX_W-1:0]),
        .in_wdata  (req_wdata),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_idx   (mem_idx),
        .mem_wdata (mem_wdata),
        .ack       (cmd_accept),
        .code      (resp_code),
        .rword     (resp_data)
    );

    cmt_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk   (clk),
        .we    (mem_we),
        .idx   (mem_idx),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

endmodule

// File: rtl/cmt_checks.sv
module cmt_checks #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        req_cmd,
    input logic              cmd_accept,
    input logic [1:0]        resp_code,
    input logic [DATA_W-1:0] resp_data
);

    p_one_cycle_ack_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_accept |=> !cmd_accept);

    p_quiet_outputs_r4: assert property (@(posedge clk) disable iff (rst)
        !cmd_accept |-> (resp_code == 2'b00 && resp_data == '0));

    p_valid_code_r3: assert property (@(posedge clk) disable iff (rst)
        resp_code != 2'b00 |-> (resp_code == 2'b01 && cmd_accept));

    p_ack_after_cmd_r8: assert property (@(posedge clk) disable iff (rst)
        cmd_accept |-> ($past(req_cmd, 2) == 3'b001 || $past(req_cmd, 2) == 3'b010));

    p_reset_clears_r7: assert property (@(posedge clk)
        $past(rst) |-> (!cmd_accept && resp_code == 2'b00 && resp_data == '0));

endmodule

bind cmd_mem_target cmt_checks #(.DATA_W(DATA_W)) u_checks (
    .clk        (clk),
    .rst        (rst),
    .req_cmd    (req_cmd),
    .cmd_accept (cmd_accept),
    .resp_code  (resp_code),
    .resp_data  (resp_data)
);

// File: tb/cmd_mem_target_bench.sv
`timescale 1ns/1ps
module cmd_mem_target_bench;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int DEPTH  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [2:0]        req_cmd = 3'b000;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              cmd_accept;
    logic [1:0]        resp_code;
    logic [DATA_W-1:0] resp_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [DATA_W-1:0] model [DEPTH];
    bit                known [DEPTH];

    always #2 clk = ~clk;

    cmd_mem_target #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_cmd_mem_target (
        .clk        (clk),
        .rst        (rst),
        .req_cmd    (req_cmd),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .cmd_accept (cmd_accept),
        .resp_code  (resp_code),
        .resp_data  (resp_data)
    );

    function automatic int slot(input logic [ADDR_W-1:0] a);
        return int'(a) % DEPTH;
    endfunction

    function automatic logic [1:0] want_code(input bit is_read);
        return is_read ? 2'b01 : 2'b00;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_quiet(input string req);
        check(req, {63'd0, cmd_accept}, 64'd0);
        check(req, {62'd0, resp_code}, 64'd0);
        check(req, {32'd0, resp_data}, 64'd0);
    endtask

    // one command: present, check latency, take accept, withdraw, check single accept
    task automatic do_op(input bit is_read, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        req_cmd   = is_read ? 3'b010 : 3'b001;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        check_quiet(is_read ? "R3 no early ack" : "R2 no early ack");
        @(negedge clk);
        check(is_read ? "R3 accept" : "R2 accept", {63'd0, cmd_accept}, 64'd1);
        check(is_read ? "R3 code" : "R2 code", {62'd0, resp_code}, {62'd0, want_code(is_read)});
        if (is_read && known[slot(a)])
            check("R3 data", {32'd0, resp_data}, {32'd0, model[slot(a)]});
        if (!is_read) begin
            model[slot(a)] = d;
            known[slot(a)] = 1'b1;
        end
        req_cmd = 3'b000;
        @(negedge clk);
        check_quiet("R5 single accept");
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;

        repeat (3) @(negedge clk);
        check_quiet("R7 reset state");
        rst = 1'b0;
        @(negedge clk);
        check_quiet("R4 idle after reset");

        // directed basic write and read
        do_op(1'b0, 8'h05, 32'hDEAD_BEEF);
        do_op(1'b1, 8'h05, 32'h0);

        // R6 aliasing through upper address bits
        do_op(1'b0, 8'h03, 32'h1111_2222);
        do_op(1'b1, 8'h13, 32'h0);
        do_op(1'b0, 8'hF3, 32'h3333_4444);
        do_op(1'b1, 8'h03, 32'h0);
        check("R6 alias model", {32'd0, model[3]}, {32'd0, 32'h3333_4444});

        // R1 unknown codes are ignored and leave memory intact
        for (int c = 3; c < 8; c++) begin
            @(negedge clk);
            req_cmd   = 3'(c);
            req_addr  = 8'h05;
            req_wdata = 32'h0BAD_0BAD;
            repeat (2) begin
                @(negedge clk);
                check_quiet("R1 unknown code ignored");
            end
        end
        req_cmd = 3'b000;
        do_op(1'b1, 8'h05, 32'h0);

        // R5 holding the request through the accept cycle yields one accept
        @(negedge clk);
        req_cmd = 3'b001; req_addr = 8'h0A; req_wdata = 32'hA5A5_5A5A;
        @(negedge clk);
        @(negedge clk);
        check("R5 held accept", {63'd0, cmd_accept}, 64'd1);
        model[10] = 32'hA5A5_5A5A; known[10] = 1'b1;
        @(negedge clk);
        check("R5 held no second accept", {63'd0, cmd_accept}, 64'd0);
        req_cmd = 3'b000;
        @(negedge clk);
        check_quiet("R5 held then dropped");
        do_op(1'b1, 8'h0A, 32'h0);

        // R7 reset in the middle of a read
        @(negedge clk);
        req_cmd = 3'b010; req_addr = 8'h05;
        @(negedge clk);
        rst = 1'b1;
        req_cmd = 3'b000;
        @(negedge clk);
        check_quiet("R7 reset abandons read");
        rst = 1'b0;
        @(negedge clk);
        check_quiet("R7 quiet after reset");

        // R7 reset in the middle of a write: word becomes unknown
        @(negedge clk);
        req_cmd = 3'b001; req_addr = 8'h07; req_wdata = 32'h7777_7777;
        @(negedge clk);
        rst = 1'b1;
        req_cmd = 3'b000;
        known[7] = 1'b0;
        @(negedge clk);
        check_quiet("R7 reset abandons write");
        rst = 1'b0;

        // constrained random mix
        for (int n = 0; n < 300; n++) begin
            logic [ADDR_W-1:0] a;
            logic [DATA_W-1:0] d;
            bit rd;
            a  = ADDR_W'($urandom);
            d  = $urandom;
            rd = ($urandom % 10) >= 6;
            do_op(rd, a, d);
        end

        // R4 and R8: long idle stretch stays quiet
        repeat (5) begin
            @(negedge clk);
            check_quiet("R8 no accept without command");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule